// File: doc/BRIEF.md
# Register Field Access Attribute Engine

This block holds a small bank of 32-bit control and status registers in which every bit has its own access behaviour, fixed when the design is elaborated. Software reaches the bank over a plain single-cycle bus (address, read strobe, write strobe, write data, registered read data). Hardware reaches it through two per-bit inputs: an event strobe and a value. The engine applies, bit by bit, the side effects that the bit's access behaviour defines for reads, writes and hardware events, and it resolves every collision between a software access and a hardware event within one clock.

Ten behaviours are mixed freely inside one register: ordinary storage, storage that hardware may overwrite, mirrors of hardware values, three flavours of sticky status (cleared by writing one, by reading, or by either), one-cycle command pulses, write-only storage, unused holes and a read-to-acquire semaphore. The stored state of every bit is exported on a flat control vector so that surrounding logic can consume commands, settings and flags directly.

Top module: `regfieldEngine`

## Requirements
- R1: Bit b of register r takes behaviour code (b + r*ATTR_ROT) mod 10, where 0 = storage, 1 = hardware-updatable storage, 2 = hardware mirror, 3 = clear-by-writing-one status, 4 = clear-on-read status, 5 = command pulse, 6 = write-only, 7 = clear-on-read-or-write-one status, 8 = hole, 9 = semaphore; bit b of register r sits at index r*DATA_W+b of hwEvt, hwVal and ctrlOut.
- R2: While rstN is low, every bit of ctrlOut and rdData is 0.
- R3: rdData is registered: after a cycle with rdEn high and addr below NUM_REGS it shows that register's read value as it was before that cycle's edge; after any other cycle it is all zero. A write to an address at or above NUM_REGS changes nothing.
- R4: A storage bit takes wrData on a write and reads back its stored value.
- R5: A hardware-updatable bit takes wrData on a write, takes hwVal when hwEvt is high, and hwEvt wins when both happen in the same cycle; it reads back its stored value.
- R6: A hardware-mirror bit reads back the current hwVal, ignores writes, and shows 0 on ctrlOut.
- R7: A clear-by-writing-one status bit is set by hwEvt, cleared by a write whose data bit is 1, unchanged by a write of 0 or by a read, and reads back its value.
- R8: A clear-on-read status bit is set by hwEvt, returns its value on a read and is 0 afterwards, and ignores writes.
- R9: A clear-on-read-or-write-one status bit is set by hwEvt and cleared by a read or by a write of 1; a write of 0 leaves it unchanged.
- R10: A command-pulse bit always reads 0; a write of 1 raises its ctrlOut bit for exactly the following cycle unless it is written with 1 again.
- R11: A write-only bit stores wrData on a write, shows it on ctrlOut, and always reads 0.
- R12: A hole bit ignores writes and hardware inputs, reads 0 and shows 0 on ctrlOut.
- R13: A semaphore bit returns its old value to a read and is 1 after any read; a write of 0 clears it and outranks a read in the same cycle; a write of 1 has no effect.
- R14: When hwEvt sets a status bit (codes 3, 4, 7) in the same cycle that software clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Register index for the bus access |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data |
| hwEvt | input | NUM_REGS*DATA_W | Per-bit hardware event strobe |
| hwVal | input | NUM_REGS*DATA_W | Per-bit hardware value |
| ctrlOut | output | NUM_REGS*DATA_W | Stored state of every bit |

## Verification
The bench builds the engine with three registers of 32 bits and a rotation of 3, so each of the ten behaviour codes lands on several bit positions of every register and the codes shift between registers, which catches a decoder that ignores the register index. With three registers the two-bit address leaves index 3 unused, which brings reads and writes to a missing register within reach. Directed sequences force reads and writes in the same cycle, hardware events colliding with software clears, and back-to-back semaphore reads, before a long stretch of mixed random traffic compared against a behavioural model on every clock.

// File: rtl/regfieldPkg.sv
package regfieldPkg;

  typedef enum logic [3:0] {
    FA_PLAIN     = 4'd0,
    FA_HWUPD     = 4'd1,
    FA_MIRROR    = 4'd2,
    FA_CLR1      = 4'd3,
    FA_RDCLR     = 4'd4,
    FA_PULSE     = 4'd5,
    FA_WRONLY    = 4'd6,
    FA_EITHERCLR = 4'd7,
    FA_HOLE      = 4'd8,
    FA_SEMA      = 4'd9
  } fieldAttr_e;

  localparam int ATTR_COUNT = 10;

  // Behaviour of bit b in register r for a given rotation
  function automatic fieldAttr_e attrOf(input int r, input int b, input int rot);
    return fieldAttr_e'((b + r * rot) % ATTR_COUNT);
  endfunction

  // Per-register access strobes from control to datapath
  typedef struct packed {
    logic rd;
    logic wr;
  } regStrobe_t;

endpackage

// File: rtl/regfieldCtrl.sv
module regfieldCtrl
  import regfieldPkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int ADDR_W   = 2
) (
  input  logic                      rdEn,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         addr,
  output regStrobe_t [NUM_REGS-1:0] strobes
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_dec
    logic hit;
    assign hit          = (addr == ADDR_W'(r));
    assign strobes[r].rd = rdEn & hit;
    assign strobes[r].wr = wrEn & hit;
  end

endmodule

// File: rtl/regfieldDatapath.sv
module regfieldDatapath
  import regfieldPkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int DATA_W   = 32,
  parameter int ATTR_ROT = 3,
  localparam int TOT_W   = NUM_REGS * DATA_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  regStrobe_t [NUM_REGS-1:0] strobes,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [TOT_W-1:0]          hwEvt,
  input  logic [TOT_W-1:0]          hwVal,
  output logic [TOT_W-1:0]          ctrlOut,
  output logic [DATA_W-1:0]         rdData
);

  logic [NUM_REGS-1:0][DATA_W-1:0] readVal;
  logic [DATA_W-1:0]               rdNext;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam fieldAttr_e ATTR = attrOf(r, b, ATTR_ROT);
      localparam int IDX = r * DATA_W + b;

      logic stQ;
      logic stD;
      logic unusedTap;

      assign unusedTap = hwEvt[IDX] ^ hwVal[IDX];

      // Next state per behaviour
      if (ATTR == FA_PLAIN || ATTR == FA_WRONLY) begin : g_store
        assign stD = strobes[r].wr ? wrData[b] : stQ;
      end else if (ATTR == FA_HWUPD) begin : g_hwupd
        assign stD = hwEvt[IDX] ? hwVal[IDX] : (strobes[r].wr ? wrData[b] : stQ);
      end else if (ATTR == FA_CLR1) begin : g_clr1
        assign stD = hwEvt[IDX] | (stQ & ~(strobes[r].wr & wrData[b]));
      end else if (ATTR == FA_RDCLR) begin : g_rdclr
        assign stD = hwEvt[IDX] | (stQ & ~strobes[r].rd);
      end else if (ATTR == FA_EITHERCLR) begin : g_either
        assign stD = hwEvt[IDX] | (stQ & ~(strobes[r].rd | (strobes[r].wr & wrData[b])));
      end else if (ATTR == FA_PULSE) begin : g_pulse
        assign stD = strobes[r].wr & wrData[b];
      end else if (ATTR == FA_SEMA) begin : g_sema
        assign stD = (strobes[r].wr & ~wrData[b]) ? 1'b0 : (strobes[r].rd | stQ);
      end else begin : g_none
        assign stD = 1'b0;
      end

      // Read value per behaviour
      if (ATTR == FA_MIRROR) begin : g_rdhw
        assign readVal[r][b] = hwVal[IDX];
      end else if (ATTR == FA_PULSE || ATTR == FA_WRONLY || ATTR == FA_HOLE) begin : g_rdzero
        assign readVal[r][b] = 1'b0;
      end else begin : g_rdstate
        assign readVal[r][b] = stQ;
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stQ <= 1'b0;
        else       stQ <= stD;
      end

      assign ctrlOut[IDX] = stQ;
    end
  end

  always_comb begin
    rdNext = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (strobes[r].rd) rdNext = rdNext | readVal[r];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

endmodule

// File: rtl/regfieldEngine.sv
module regfieldEngine
  import regfieldPkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int DATA_W   = 32,
  parameter int ATTR_ROT = 3,
  localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int TOT_W   = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [TOT_W-1:0]  hwEvt,
  input  logic [TOT_W-1:0]  hwVal,
  output logic [TOT_W-1:0]  ctrlOut
);

  regStrobe_t [NUM_REGS-1:0] strobes;

  regfieldCtrl #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W)
  ) u_ctrl (
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .addr   (addr),
    .strobes(strobes)
  );

  regfieldDatapath #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .ATTR_ROT(ATTR_ROT)
  ) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (wrData),
    .hwEvt  (hwEvt),
    .hwVal  (hwVal),
    .ctrlOut(ctrlOut),
    .rdData (rdData)
  );

endmodule

// File: rtl/regfieldChecker.sv
module regfieldChecker
  import regfieldPkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int DATA_W   = 32,
  parameter int ATTR_ROT = 3,
  localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int TOT_W   = NUM_REGS * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              rdEn,
  input logic              wrEn,
  input logic [DATA_W-1:0] rdData,
  input logic [TOT_W-1:0]  hwEvt,
  input logic [TOT_W-1:0]  hwVal,
  input logic [TOT_W-1:0]  ctrlOut
);

  logic [TOT_W-1:0] mirM, pulseM, zeroRdM, holeM, statM, hwuM, semaM;

  always_comb begin
    mirM = '0; pulseM = '0; zeroRdM = '0; holeM = '0; statM = '0; hwuM = '0; semaM = '0;
    for (int i = 0; i < TOT_W; i++) begin
      case (attrOf(i / DATA_W, i % DATA_W, ATTR_ROT))
        FA_MIRROR: mirM[i] = 1'b1;
        FA_PULSE:  begin pulseM[i] = 1'b1; zeroRdM[i] = 1'b1; end
        FA_WRONLY: zeroRdM[i] = 1'b1;
        FA_HOLE:   begin holeM[i] = 1'b1; zeroRdM[i] = 1'b1; end
        FA_CLR1, FA_RDCLR, FA_EITHERCLR: statM[i] = 1'b1;
        FA_HWUPD:  hwuM[i] = 1'b1;
        FA_SEMA:   semaM[i] = 1'b1;
        default:   ;
      endcase
    end
  end

  logic              addrOk;
  logic [ADDR_W-1:0] sel, selQ;
  logic [DATA_W-1:0] mirSlice, hwSlice, zeroSlice, ctrlSliceQ, semaSliceQ;

  assign addrOk    = rdEn && (int'(addr) < NUM_REGS);
  assign sel       = (int'(addr) < NUM_REGS) ? addr : '0;
  assign mirSlice  = mirM[sel*DATA_W +: DATA_W];
  assign hwSlice   = hwVal[sel*DATA_W +: DATA_W];
  assign zeroSlice = zeroRdM[sel*DATA_W +: DATA_W];
  assign ctrlSliceQ = ctrlOut[selQ*DATA_W +: DATA_W];
  assign semaSliceQ = semaM[selQ*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selQ <= '0;
    else       selQ <= sel;
  end

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !addrOk |=> rdData == '0);  // R3

  AST_MIRROR_FOLLOWS_HW: assert property (@(posedge clk) disable iff (!rstN)
    addrOk |=> (rdData & $past(mirSlice)) == ($past(hwSlice) & $past(mirSlice)));  // R6

  AST_ZERO_READ_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    addrOk |=> (rdData & $past(zeroSlice)) == '0);  // R11

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (ctrlOut & pulseM) == '0);  // R10

  AST_HOLE_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlOut & holeM) == '0);  // R12

  AST_SEMA_READ_ACQUIRES: assert property (@(posedge clk) disable iff (!rstN)
    (addrOk && !wrEn) |=> (ctrlSliceQ & semaSliceQ) == semaSliceQ);  // R13

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (|(hwEvt & statM)) |=> (ctrlOut & $past(hwEvt & statM)) == $past(hwEvt & statM));  // R14

  AST_HW_UPDATE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|(hwEvt & hwuM)) |=> (ctrlOut & $past(hwEvt & hwuM)) == $past(hwVal & hwEvt & hwuM));  // R5

endmodule

bind regfieldEngine regfieldChecker #(
  .NUM_REGS(NUM_REGS),
  .DATA_W  (DATA_W),
  .ATTR_ROT(ATTR_ROT)
) u_regfieldChecker (
  .clk    (clk),
  .rstN   (rstN),
  .addr   (addr),
  .rdEn   (rdEn),
  .wrEn   (wrEn),
  .rdData (rdData),
  .hwEvt  (hwEvt),
  .hwVal  (hwVal),
  .ctrlOut(ctrlOut)
);

// File: tb/regfieldEngine_bench.sv
module regfieldEngine_bench;

  localparam int NUM_REGS = 3;
  localparam int DATA_W   = 32;
  localparam int ROT      = 3;
  localparam int ADDR_W   = 2;
  localparam int TOT_W    = NUM_REGS * DATA_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              rdEn = 1'b0;
  logic              wrEn = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic [TOT_W-1:0]  hwEvt = '0;
  logic [TOT_W-1:0]  hwVal = '0;
  logic [TOT_W-1:0]  ctrlOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  regfieldEngine #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .ATTR_ROT(ROT)
  ) u_regfieldEngine (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .hwEvt(hwEvt), .hwVal(hwVal), .ctrlOut(ctrlOut)
  );

  // R1: behaviour code of each bit, from the requirement's formula
  function automatic int code(int r, int b);
    return (b + r * ROT) % 10;
  endfunction

  function automatic string tagFor(int c);
    case (c)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7/R14";
      4: return "R8/R14";
      5: return "R10";
      6: return "R11";
      7: return "R9/R14";
      8: return "R12";
      default: return "R13";
    endcase
  endfunction

  // Behavioural reference model
  logic [DATA_W-1:0] mState [NUM_REGS];
  logic [DATA_W-1:0] mNext  [NUM_REGS];
  logic [DATA_W-1:0] mRd, mRdNext;
  int                mRdReg;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) mState[r] <= '0;
      mRd <= '0;
      mRdReg <= -1;
    end else begin
      mRdNext = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
        bit rd, wr;
        rd = rdEn && (int'(addr) == r);
        wr = wrEn && (int'(addr) == r);
        for (int b = 0; b < DATA_W; b++) begin
          bit q, d, e, v, n, rv;
          q = mState[r][b]; d = wrData[b];
          e = hwEvt[r*DATA_W+b]; v = hwVal[r*DATA_W+b];
          n = 1'b0; rv = 1'b0;
          case (code(r, b))
            0: begin n = wr ? d : q; rv = q; end
            1: begin n = e ? v : (wr ? d : q); rv = q; end
            2: begin n = 1'b0; rv = v; end
            3: begin n = (wr && d) ? 1'b0 : q; if (e) n = 1'b1; rv = q; end
            4: begin n = rd ? 1'b0 : q; if (e) n = 1'b1; rv = q; end
            5: begin n = wr && d; rv = 1'b0; end
            6: begin n = wr ? d : q; rv = 1'b0; end
            7: begin n = (rd || (wr && d)) ? 1'b0 : q; if (e) n = 1'b1; rv = q; end
            8: begin n = 1'b0; rv = 1'b0; end
            default: begin
              n = q;
              if (rd) n = 1'b1;
              if (wr && !d) n = 1'b0;
              rv = q;
            end
          endcase
          mNext[r][b] = n;
          if (rd) mRdNext[b] = rv;
        end
      end
      for (int r = 0; r < NUM_REGS; r++) mState[r] <= mNext[r];
      mRd <= mRdNext;
      mRdReg <= (rdEn && int'(addr) < NUM_REGS) ? int'(addr) : -1;
    end
  end

  task automatic compare();
    checks++;
    if (rdData !== mRd) begin
      int bad;
      bad = 0;
      for (int b = DATA_W - 1; b >= 0; b--) if (rdData[b] !== mRd[b]) bad = b;
      fails++;
      $display("FAIL %s rdData bit %0d reg %0d: actual %h expected %h",
               (mRdReg < 0) ? "R3" : tagFor(code(mRdReg, bad)), bad, mRdReg, rdData, mRd);
    end
    for (int r = 0; r < NUM_REGS; r++) begin
      checks++;
      if (ctrlOut[r*DATA_W +: DATA_W] !== mState[r]) begin
        int bad;
        bad = 0;
        for (int b = DATA_W - 1; b >= 0; b--) if (ctrlOut[r*DATA_W+b] !== mState[r][b]) bad = b;
        fails++;
        $display("FAIL %s ctrlOut reg %0d bit %0d: actual %h expected %h",
                 tagFor(code(r, bad)), r, bad, ctrlOut[r*DATA_W +: DATA_W], mState[r]);
      end
    end
  endtask

  task automatic step(bit rd, bit wr, int a, logic [DATA_W-1:0] d,
                      logic [TOT_W-1:0] e, logic [TOT_W-1:0] v);
    rdEn = rd; wrEn = wr; addr = ADDR_W'(a); wrData = d; hwEvt = e; hwVal = v;
    @(negedge clk);
    compare();
  endtask

  function automatic logic [TOT_W-1:0] rnd96();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    checks++;
    if (rdData !== '0) begin
      fails++; $display("FAIL R2 rdData in reset: actual %h expected 0", rdData);
    end
    checks++;
    if (ctrlOut !== '0) begin
      fails++; $display("FAIL R2 ctrlOut in reset: actual %h expected 0", ctrlOut);
    end
    rstN = 1'b1;
    @(negedge clk);
    compare();

    for (int r = 0; r < NUM_REGS; r++) begin
      logic [TOT_W-1:0] ev;
      ev = '0; ev[r*DATA_W +: DATA_W] = '1;
      step(0, 1, r, '1, '0, '0);               // R4 R10 R11 write ones
      step(1, 0, r, '0, '0, rnd96());          // R6 mirror read, R13 acquire
      step(1, 0, r, '0, '0, '0);               // R13 second read returns 1
      step(0, 1, r, '1, ev, rnd96());          // R14 set beats write-one clear, R5
      step(1, 0, r, '0, ev, '0);               // R14 set beats read clear
      step(1, 0, r, '0, '0, '0);               // R8 R9 read clears
      step(1, 1, r, '0, ev, '1);               // R13 write 0 outranks read, R9 write 0
      step(0, 1, r, 32'hA5A5_5A5A, '0, '0);    // R7 partial clear
      step(1, 0, r, '0, '0, '1);
      step(0, 0, r, '0, '0, '0);               // R10 pulse drops, R3 idle read
    end
    step(0, 1, 3, '1, '0, '0);                 // R3 write to missing register
    step(1, 0, 3, '0, '0, '1);                 // R3 read of missing register
    step(0, 0, 0, '0, '0, '0);

    for (int i = 0; i < 4000; i++) begin
      logic [DATA_W-1:0] d;
      d = (i % 7 == 0) ? '1 : ((i % 11 == 0) ? '0 : $urandom());
      step($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, $urandom_range(0, 3), d,
           rnd96() & rnd96() & rnd96(), rnd96());
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule